// File: doc/BRIEF.md
# Fence-Gated Issue and Reorder Tracker

This block models the allocation side of an out-of-order core. Each clock an in-order front end offers up to four micro-ops. Each accepted micro-op takes one reorder-buffer entry. Micro-ops that need an execution port also take scheduler slots. Micro-ops handled entirely in the front end take none and enter the reorder buffer already finished. Execution units report completions by reorder index. A completion marks the entry finished and releases the scheduler slots recorded for it. Retirement then commits finished entries strictly from the oldest end.

A fence micro-op halts issue itself, not just dispatch. Once a fence is accepted, no younger micro-op is accepted until every older entry has retired, and issue resumes one cycle after that happens. The scheduler is much smaller than the reorder buffer. When it fills, the front end stalls even though reorder entries remain, and it then advances only as fast as completions release slots.

Top module: `rob_issue_tracker`

## Requirements
- R1: While rst_ni is low, rob_count_o, sched_count_o, retire_cnt_o and fence_wait_o are all zero.
- R2: Kind encoding per slot (2 bits at fe_kind_i[2k+1:2k]) is 0 = execute, 1 = front-end only, 2 = micro-fused, 3 = fence. Slots are taken in order from slot 0, the first slot with fe_valid_i low ends the group, and at most ISSUE_W micro-ops issue per cycle. issue_cnt_o reports the number accepted, and each accepted op adds one to rob_count_o in the next cycle.
- R3: An accepted execute op adds 1 to sched_count_o, a micro-fused op adds 2, and front-end-only and fence ops add 0. The increase appears in the next cycle.
- R4: Room is judged from the occupancy at the start of the cycle. If the next op lacks a reorder entry or enough scheduler slots, that op and all younger ops in the group are held, and fe_stall_o is high whenever a valid leading op is held.
- R5: A completion in cycle c, given on a port with cmpl_valid_i set and the reorder index in cmpl_idx_i, marks the entry finished. It lowers sched_count_o by that entry's recorded slots from cycle c+1, and the entry may retire from cycle c+1. Two ports naming the same entry free it once.
- R6: A completion naming an empty entry, an already-finished entry or an index at or beyond ROB_DEPTH changes nothing.
- R7: Each cycle retirement commits the longest run of finished entries starting at the oldest, up to RETIRE_W. retire_cnt_o shows that run in the same cycle, and rob_count_o drops by it in the next cycle.
- R8: Front-end-only and fence ops are finished on entry, so a group of them issued into an empty buffer retires in full in the next cycle.
- R9: Ops younger than an accepted fence in the same group are held. fence_wait_o is high and issue_cnt_o is zero while any entry older than the fence remains. The first younger op issues in the cycle after the last older entry retires.
- R10: rob_count_o never exceeds ROB_DEPTH and sched_count_o never exceeds SCHED_CAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fe_valid_i | input | ISSUE_W | Per-slot offer from the front end |
| fe_kind_i | input | 2*ISSUE_W | Per-slot micro-op kind |
| cmpl_valid_i | input | CMPL_W | Completion port valid |
| cmpl_idx_i | input | CMPL_W*IDX_W | Reorder index per completion port |
| issue_cnt_o | output | ISS_CNT_W | Micro-ops accepted this cycle |
| fe_stall_o | output | 1 | A valid leading micro-op was held |
| retire_cnt_o | output | RET_CNT_W | Entries retiring this cycle |
| rob_count_o | output | ROB_CNT_W | Reorder-buffer occupancy |
| sched_count_o | output | SCH_CNT_W | Scheduler-slot occupancy |
| fence_wait_o | output | 1 | A fence is holding issue |

## Verification
Issue, completion and retirement can all fall in the same cycle. The occupancy counters must then apply the added entries, the released slots and the committed entries together, while the issue decision still uses the start-of-cycle counts. The bench provokes this with random phases. A low completion rate fills the scheduler or the reorder buffer, and a high completion rate keeps retirement and issue overlapping, with fences mixed in. Every cycle, the bench compares all counts and both stall indicators against its own queue model.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef enum logic [1:0] {
    UOP_EXEC   = 2'd0,
    UOP_FEONLY = 2'd1,
    UOP_FUSED  = 2'd2,
    UOP_FENCE  = 2'd3
  } uop_kind_e;

  function automatic logic [1:0] sched_slots(uop_kind_e k);
    case (k)
      UOP_EXEC:  return 2'd1;
      UOP_FUSED: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic logic done_at_issue(uop_kind_e k);
    return (k == UOP_FEONLY) || (k == UOP_FENCE);
  endfunction

  // off must be below depth
  function automatic int unsigned ring_add(int unsigned base, int unsigned off, int unsigned depth);
    int unsigned t;
    t = base + off;
    if (t >= depth) t = t - depth;
    return t;
  endfunction

  function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned depth);
    return (to >= from) ? (to - from) : (to + depth - from);
  endfunction
endpackage

// File: rtl/rit_issue_sel.sv
module rit_issue_sel
  import rit_pkg::*;
#(
  parameter int ISSUE_W   = 4,
  parameter int ROB_DEPTH = 224,
  parameter int SCHED_CAP = 97,
  parameter int ROB_CNT_W = 8,
  parameter int SCH_CNT_W = 7,
  parameter int ISS_CNT_W = 3,
  parameter int SCH_ADD_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ISSUE_W-1:0]     valid_i,
  input  logic [2*ISSUE_W-1:0]   kind_i,
  input  logic [ROB_CNT_W-1:0]   rob_cnt_i,
  input  logic [SCH_CNT_W-1:0]   sch_cnt_i,
  input  logic                   allow_i,
  output logic [ISS_CNT_W-1:0]   n_issue_o,
  output logic [SCH_ADD_W-1:0]   sch_add_o,
  output logic                   fence_o,
  output logic [ISS_CNT_W-1:0]   fence_pos_o,
  output logic                   stall_o
);
  always_comb begin
    int unsigned n, s, lead, rob_free, sch_free, need;
    logic stop, gap;
    uop_kind_e kd;
    n = 0; s = 0; lead = 0; need = 0;
    gap = 1'b0;
    stop = !allow_i;
    kd = UOP_EXEC;
    fence_o = 1'b0;
    fence_pos_o = '0;
    rob_free = ROB_DEPTH - 32'(rob_cnt_i);
    sch_free = SCHED_CAP - 32'(sch_cnt_i);
    for (int k = 0; k < ISSUE_W; k++) begin
      kd = uop_kind_e'(kind_i[2*k +: 2]);
      need = 32'(sched_slots(kd));
      if (!valid_i[k]) gap = 1'b1;
      if (!gap) lead = lead + 1;
      if (!stop) begin
        // in-order, all-or-nothing per op
        if (!valid_i[k] || (n + 1 > rob_free) || (s + need > sch_free)) begin
          stop = 1'b1;
        end else begin
          n = n + 1;
          s = s + need;
          if (kd == UOP_FENCE) begin
            fence_o = 1'b1;
            fence_pos_o = ISS_CNT_W'(k);
            stop = 1'b1;
          end
        end
      end
    end
    n_issue_o = ISS_CNT_W'(n);
    sch_add_o = SCH_ADD_W'(s);
    stall_o = (lead > n);
  end

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_i |-> (n_issue_o == '0));
  p_rob_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rob_cnt_i) + 32'(n_issue_o)) <= 32'(ROB_DEPTH));
  p_sch_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sch_cnt_i) + 32'(sch_add_o)) <= 32'(SCHED_CAP));
endmodule

// File: rtl/rit_rob.sv
module rit_rob
  import rit_pkg::*;
#(
  parameter int ISSUE_W    = 4,
  parameter int RETIRE_W   = 8,
  parameter int CMPL_W     = 2,
  parameter int ROB_DEPTH  = 224,
  parameter int IDX_W      = 8,
  parameter int ROB_CNT_W  = 8,
  parameter int ISS_CNT_W  = 3,
  parameter int RET_CNT_W  = 4,
  parameter int SCH_FREE_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ISS_CNT_W-1:0]      n_issue_i,
  input  logic [2*ISSUE_W-1:0]      kind_i,
  input  logic [CMPL_W-1:0]         cmpl_valid_i,
  input  logic [CMPL_W*IDX_W-1:0]   cmpl_idx_i,
  output logic [IDX_W-1:0]          head_o,
  output logic [IDX_W-1:0]          tail_o,
  output logic [ROB_CNT_W-1:0]      cnt_o,
  output logic [RET_CNT_W-1:0]      retire_cnt_o,
  output logic [SCH_FREE_W-1:0]     sch_free_o
);
  logic             valid_q [ROB_DEPTH];
  logic             done_q  [ROB_DEPTH];
  logic [1:0]       need_q  [ROB_DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [ROB_CNT_W-1:0] cnt_q;

  logic [IDX_W-1:0] c_ix  [CMPL_W];
  logic [CMPL_W-1:0] c_hit;

  function automatic logic [IDX_W-1:0] wrap(logic [IDX_W-1:0] b, int unsigned off);
    return IDX_W'(ring_add(32'(b), off, ROB_DEPTH));
  endfunction

  // oldest-first retirement run
  always_comb begin
    int unsigned r;
    logic stop;
    logic [IDX_W-1:0] ix;
    r = 0;
    stop = 1'b0;
    ix = '0;
    for (int k = 0; k < RETIRE_W; k++) begin
      ix = wrap(head_q, k);
      if (!stop && valid_q[ix] && done_q[ix]) r = r + 1;
      else stop = 1'b1;
    end
    retire_cnt_o = RET_CNT_W'(r);
  end

  // completions: ignore empty, finished, out-of-range and duplicate
  always_comb begin
    int unsigned f;
    f = 0;
    for (int p = 0; p < CMPL_W; p++) begin
      c_ix[p] = cmpl_idx_i[p*IDX_W +: IDX_W];
      c_hit[p] = 1'b0;
      if (cmpl_valid_i[p] && (32'(c_ix[p]) < ROB_DEPTH)) begin
        if (valid_q[c_ix[p]] && !done_q[c_ix[p]]) c_hit[p] = 1'b1;
      end
      for (int q = 0; q < p; q++) begin
        if (c_hit[q] && (c_ix[q] == c_ix[p])) c_hit[p] = 1'b0;
      end
      if (c_hit[p]) f = f + 32'(need_q[c_ix[p]]);
    end
    sch_free_o = SCH_FREE_W'(f);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROB_DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        need_q[i]  <= 2'd0;
      end
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int k = 0; k < RETIRE_W; k++) begin
        if (k < 32'(retire_cnt_o)) valid_q[wrap(head_q, k)] <= 1'b0;
      end
      for (int p = 0; p < CMPL_W; p++) begin
        if (c_hit[p]) done_q[c_ix[p]] <= 1'b1;
      end
      for (int k = 0; k < ISSUE_W; k++) begin
        if (k < 32'(n_issue_i)) begin
          valid_q[wrap(tail_q, k)] <= 1'b1;
          done_q[wrap(tail_q, k)]  <= done_at_issue(uop_kind_e'(kind_i[2*k +: 2]));
          need_q[wrap(tail_q, k)]  <= sched_slots(uop_kind_e'(kind_i[2*k +: 2]));
        end
      end
      head_q <= wrap(head_q, 32'(retire_cnt_o));
      tail_q <= wrap(tail_q, 32'(n_issue_i));
      cnt_q  <= cnt_q + ROB_CNT_W'(n_issue_i) - ROB_CNT_W'(retire_cnt_o);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;

  p_rob_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= 32'(ROB_DEPTH));
  p_retire_le_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(retire_cnt_o) <= 32'(cnt_q));
endmodule

// File: rtl/rit_sched_ctr.sv
module rit_sched_ctr #(
  parameter int SCHED_CAP  = 97,
  parameter int SCH_CNT_W  = 7,
  parameter int SCH_ADD_W  = 4,
  parameter int SCH_FREE_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SCH_ADD_W-1:0]  add_i,
  input  logic [SCH_FREE_W-1:0] free_i,
  output logic [SCH_CNT_W-1:0]  cnt_o
);
  logic [SCH_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + SCH_CNT_W'(add_i) - SCH_CNT_W'(free_i);
  end

  assign cnt_o = cnt_q;

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= 32'(SCHED_CAP));
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(free_i) <= 32'(cnt_q));
endmodule

// File: rtl/rob_issue_tracker.sv
module rob_issue_tracker
  import rit_pkg::*;
#(
  parameter int ISSUE_W   = 4,
  parameter int RETIRE_W  = 8,
  parameter int CMPL_W    = 2,
  parameter int ROB_DEPTH = 224,
  parameter int SCHED_CAP = 97,
  localparam int IDX_W      = $clog2(ROB_DEPTH),
  localparam int ROB_CNT_W  = $clog2(ROB_DEPTH + 1),
  localparam int SCH_CNT_W  = $clog2(SCHED_CAP + 1),
  localparam int ISS_CNT_W  = $clog2(ISSUE_W + 1),
  localparam int RET_CNT_W  = $clog2(RETIRE_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ISSUE_W-1:0]      fe_valid_i,
  input  logic [2*ISSUE_W-1:0]    fe_kind_i,
  input  logic [CMPL_W-1:0]       cmpl_valid_i,
  input  logic [CMPL_W*IDX_W-1:0] cmpl_idx_i,
  output logic [ISS_CNT_W-1:0]    issue_cnt_o,
  output logic                    fe_stall_o,
  output logic [RET_CNT_W-1:0]    retire_cnt_o,
  output logic [ROB_CNT_W-1:0]    rob_count_o,
  output logic [SCH_CNT_W-1:0]    sched_count_o,
  output logic                    fence_wait_o
);
  localparam int SCH_ADD_W  = $clog2(2*ISSUE_W + 1);
  localparam int SCH_FREE_W = $clog2(2*CMPL_W + 1);

  logic [IDX_W-1:0]      head, tail;
  logic [ISS_CNT_W-1:0]  n_issue, fence_pos;
  logic [SCH_ADD_W-1:0]  sch_add;
  logic [SCH_FREE_W-1:0] sch_free;
  logic                  fence_new, allow;
  logic                  fence_pend_q;
  logic [IDX_W-1:0]      fence_idx_q;
  int unsigned           fence_dist;
  logic                  fence_clear;

  // entries still older than the pending fence
  assign fence_dist  = ring_dist(32'(head), 32'(fence_idx_q), ROB_DEPTH);
  assign allow       = !fence_pend_q || (fence_dist == 0);
  assign fence_clear = fence_pend_q && (fence_dist <= 32'(retire_cnt_o));

  rit_issue_sel #(
    .ISSUE_W(ISSUE_W), .ROB_DEPTH(ROB_DEPTH), .SCHED_CAP(SCHED_CAP),
    .ROB_CNT_W(ROB_CNT_W), .SCH_CNT_W(SCH_CNT_W), .ISS_CNT_W(ISS_CNT_W),
    .SCH_ADD_W(SCH_ADD_W)
  ) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(fe_valid_i), .kind_i(fe_kind_i),
    .rob_cnt_i(rob_count_o), .sch_cnt_i(sched_count_o), .allow_i(allow),
    .n_issue_o(n_issue), .sch_add_o(sch_add),
    .fence_o(fence_new), .fence_pos_o(fence_pos), .stall_o(fe_stall_o)
  );

  rit_rob #(
    .ISSUE_W(ISSUE_W), .RETIRE_W(RETIRE_W), .CMPL_W(CMPL_W),
    .ROB_DEPTH(ROB_DEPTH), .IDX_W(IDX_W), .ROB_CNT_W(ROB_CNT_W),
    .ISS_CNT_W(ISS_CNT_W), .RET_CNT_W(RET_CNT_W), .SCH_FREE_W(SCH_FREE_W)
  ) u_rob (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .n_issue_i(n_issue), .kind_i(fe_kind_i),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_idx_i(cmpl_idx_i),
    .head_o(head), .tail_o(tail), .cnt_o(rob_count_o),
    .retire_cnt_o(retire_cnt_o), .sch_free_o(sch_free)
  );

  rit_sched_ctr #(
    .SCHED_CAP(SCHED_CAP), .SCH_CNT_W(SCH_CNT_W),
    .SCH_ADD_W(SCH_ADD_W), .SCH_FREE_W(SCH_FREE_W)
  ) u_sch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .add_i(sch_add), .free_i(sch_free), .cnt_o(sched_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fence_pend_q <= 1'b0;
      fence_idx_q  <= '0;
    end else if (fence_new) begin
      fence_pend_q <= 1'b1;
      fence_idx_q  <= IDX_W'(ring_add(32'(tail), 32'(fence_pos), ROB_DEPTH));
    end else if (fence_clear) begin
      fence_pend_q <= 1'b0;
    end
  end

  assign issue_cnt_o  = n_issue;
  assign fence_wait_o = fence_pend_q && (fence_dist != 0);

  p_fence_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_wait_o |-> (issue_cnt_o == '0));
  p_fence_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_clear && !fence_new) |=> !fence_wait_o);
endmodule

// File: tb/sim_rob_issue_tracker.sv
module sim_rob_issue_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4, RW = 8, CW = 2, DEPTH = 224, SCAP = 97, IDXW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0]      fe_valid = '0;
  logic [2*IW-1:0]    fe_kind = '0;
  logic [CW-1:0]      c_valid = '0;
  logic [CW*IDXW-1:0] c_idx = '0;
  logic [2:0] issue_cnt;
  logic       stall;
  logic [3:0] retire_cnt;
  logic [7:0] rob_count;
  logic [6:0] sched_count;
  logic       fence_wait;

  rob_issue_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .fe_valid_i(fe_valid), .fe_kind_i(fe_kind),
    .cmpl_valid_i(c_valid), .cmpl_idx_i(c_idx),
    .issue_cnt_o(issue_cnt), .fe_stall_o(stall), .retire_cnt_o(retire_cnt),
    .rob_count_o(rob_count), .sched_count_o(sched_count), .fence_wait_o(fence_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference queue model
  bit m_valid [DEPTH];
  bit m_done  [DEPTH];
  int m_need  [DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0, m_sch = 0, m_fidx = 0;
  bit m_fp = 0;
  int e_issue, e_retire, e_sadd, e_free, e_fpos, e_dist;
  bit e_stall, e_wait, e_fence;
  bit e_hit [CW];
  int e_hix [CW];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slots(int k);
    return (k == 0) ? 1 : (k == 2) ? 2 : 0;
  endfunction

  task automatic compute();
    int ix, n, s, lead, need, kd;
    bit stop, gap, allow;
    e_retire = 0; stop = 0;
    for (int r = 0; r < RW; r++) begin
      ix = (m_head + r) % DEPTH;
      if (!stop && m_valid[ix] && m_done[ix]) e_retire++; else stop = 1;
    end
    e_dist = m_fp ? (m_fidx - m_head + DEPTH) % DEPTH : 0;
    e_wait = m_fp && (e_dist != 0);
    allow = !m_fp || (e_dist == 0);
    n = 0; s = 0; lead = 0; gap = 0; stop = !allow; e_fence = 0; e_fpos = 0;
    for (int k = 0; k < IW; k++) begin
      kd = int'(fe_kind[2*k +: 2]);
      need = slots(kd);
      if (!fe_valid[k]) gap = 1;
      if (!gap) lead++;
      if (!stop) begin
        if (!fe_valid[k] || (m_cnt + n + 1 > DEPTH) || (m_sch + s + need > SCAP)) stop = 1;
        else begin
          n++; s += need;
          if (kd == 3) begin e_fence = 1; e_fpos = k; stop = 1; end
        end
      end
    end
    e_issue = n; e_sadd = s; e_stall = (lead > n);
    e_free = 0;
    for (int p = 0; p < CW; p++) begin
      ix = int'(c_idx[p*IDXW +: IDXW]);
      e_hix[p] = ix;
      e_hit[p] = 0;
      if (c_valid[p] && ix < DEPTH) begin
        if (m_valid[ix] && !m_done[ix]) e_hit[p] = 1;
      end
      for (int q = 0; q < p; q++) if (e_hit[q] && e_hix[q] == ix) e_hit[p] = 0;
      if (e_hit[p]) e_free += m_need[ix];
    end
  endtask

  task automatic update();
    int ix;
    for (int r = 0; r < e_retire; r++) m_valid[(m_head + r) % DEPTH] = 0;
    for (int p = 0; p < CW; p++) if (e_hit[p]) m_done[e_hix[p]] = 1;
    for (int k = 0; k < e_issue; k++) begin
      ix = (m_tail + k) % DEPTH;
      m_valid[ix] = 1;
      m_done[ix] = (fe_kind[2*k +: 2] == 2'd1) || (fe_kind[2*k +: 2] == 2'd3);
      m_need[ix] = slots(int'(fe_kind[2*k +: 2]));
    end
    if (e_fence) begin m_fp = 1; m_fidx = (m_tail + e_fpos) % DEPTH; end
    else if (m_fp && e_dist <= e_retire) m_fp = 0;
    m_head = (m_head + e_retire) % DEPTH;
    m_tail = (m_tail + e_issue) % DEPTH;
    m_cnt = m_cnt + e_issue - e_retire;
    m_sch = m_sch + e_sadd - e_free;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic cycle();
    compute();
    chk("R2 issue_cnt", int'(issue_cnt), e_issue);
    chk("R4 fe_stall", int'(stall), int'(e_stall));
    chk("R7 retire_cnt", int'(retire_cnt), e_retire);
    chk("R10 rob_count", int'(rob_count), m_cnt);
    chk("R3/R5 sched_count", int'(sched_count), m_sch);
    chk("R9 fence_wait", int'(fence_wait), int'(e_wait));
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic step();
    settle();
    cycle();
  endtask

  task automatic set_group(int k0, int k1, int k2, int k3, logic [3:0] v);
    fe_valid = v;
    fe_kind = {2'(k3), 2'(k2), 2'(k1), 2'(k0)};
  endtask

  task automatic no_cmpl();
    c_valid = '0; c_idx = '0;
  endtask

  task automatic pick_random(int pct);
    int ix;
    bit found;
    no_cmpl();
    for (int p = 0; p < CW; p++) begin
      if (m_cnt > 0 && $urandom_range(0, 99) < pct) begin
        found = 0;
        for (int t = 0; t < 8; t++) begin
          ix = (m_head + $urandom_range(0, m_cnt - 1)) % DEPTH;
          if (!found && m_valid[ix] && !m_done[ix] &&
              !(p == 1 && c_valid[0] && int'(c_idx[IDXW-1:0]) == ix)) begin
            found = 1;
            c_valid[p] = 1'b1;
            c_idx[p*IDXW +: IDXW] = IDXW'(ix);
          end
        end
      end else if ($urandom_range(0, 99) < 3) begin
        c_valid[p] = 1'b1;
        c_idx[p*IDXW +: IDXW] = IDXW'($urandom_range(0, 255));
      end
    end
  endtask

  task automatic drive_random(int cmpl_pct, int fence_pct);
    int r;
    for (int k = 0; k < IW; k++) begin
      fe_valid[k] = ($urandom_range(0, 99) < 80);
      r = $urandom_range(0, 99);
      fe_kind[2*k +: 2] = (r < fence_pct) ? 2'd3 : (r < fence_pct + 40) ? 2'd0 :
                          (r < fence_pct + 65) ? 2'd2 : 2'd1;
    end
    pick_random(cmpl_pct);
  endtask

  task automatic pick_drain();
    int ix, got;
    no_cmpl();
    got = 0;
    for (int o = 0; o < DEPTH; o++) begin
      ix = (m_head + o) % DEPTH;
      if (got < CW && m_valid[ix] && !m_done[ix]) begin
        c_valid[got] = 1'b1;
        c_idx[got*IDXW +: IDXW] = IDXW'(ix);
        got++;
      end
    end
  endtask

  initial begin
    int exec_idx, fused_idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_valid[i] = 0; m_done[i] = 0; m_need[i] = 0; end
    @(negedge clk);
    settle();
    chk("R1 rob_count", int'(rob_count), 0);
    chk("R1 sched_count", int'(sched_count), 0);
    chk("R1 retire_cnt", int'(retire_cnt), 0);
    chk("R1 fence_wait", int'(fence_wait), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: front-end-only group retires whole next cycle
    set_group(1, 1, 1, 1, 4'hf);
    step();
    set_group(0, 0, 0, 0, 4'h0);
    settle();
    chk("R8 retire_cnt", int'(retire_cnt), 4);
    cycle();
    step();

    // R9: fence holds younger ops until older retire
    exec_idx = m_tail;
    set_group(0, 3, 0, 0, 4'hf);
    settle();
    chk("R9 issue up to fence", int'(issue_cnt), 2);
    chk("R9 stall behind fence", int'(stall), 1);
    cycle();
    set_group(0, 0, 0, 0, 4'hf);
    for (int i = 0; i < 3; i++) begin
      settle();
      chk("R9 held issue", int'(issue_cnt), 0);
      chk("R9 wait flag", int'(fence_wait), 1);
      cycle();
    end
    c_valid = 2'b01; c_idx = IDXW'(exec_idx);
    step();
    no_cmpl();
    settle();
    chk("R9 older and fence retire", int'(retire_cnt), 2);
    chk("R9 still held", int'(issue_cnt), 0);
    cycle();
    settle();
    chk("R9 resume issue", int'(issue_cnt), 4);
    chk("R9 wait cleared", int'(fence_wait), 0);
    cycle();

    // R4: fill the scheduler
    set_group(0, 0, 0, 0, 4'h0);
    fused_idx = m_tail;
    set_group(2, 2, 2, 2, 4'hf);
    while (m_sch + 8 <= SCAP) step();
    settle();
    chk("R4 partial group", int'(issue_cnt), (SCAP - m_sch) / 2);
    cycle();
    set_group(0, 0, 0, 0, 4'hf);
    step();
    settle();
    chk("R4 full scheduler holds", int'(issue_cnt), 0);
    chk("R4 full scheduler stall", int'(stall), 1);
    chk("R4 scheduler at cap", int'(sched_count), SCAP);
    cycle();

    // R5: duplicate completion of a fused entry frees 2 once
    set_group(0, 0, 0, 0, 4'h0);
    c_valid = 2'b11;
    c_idx = {IDXW'(fused_idx), IDXW'(fused_idx)};
    step();
    no_cmpl();
    settle();
    chk("R5 fused frees two", int'(sched_count), SCAP - 2);
    cycle();
    // R6: finished and empty targets ignored
    c_valid = 2'b11;
    c_idx = {IDXW'((m_tail + 10) % DEPTH), IDXW'(fused_idx)};
    step();
    no_cmpl();
    settle();
    chk("R6 ignored completion", int'(sched_count), SCAP - 2);
    cycle();

    // random phases
    for (int i = 0; i < 1000; i++) begin drive_random(70, 5); step(); end
    for (int i = 0; i < 1000; i++) begin drive_random(10, 2); step(); end
    for (int i = 0; i < 1000; i++) begin drive_random(95, 15); step(); end

    // drain
    set_group(0, 0, 0, 0, 4'h0);
    for (int i = 0; i < 400; i++) begin pick_drain(); step(); end
    no_cmpl();
    settle();
    chk("R10 drained rob", int'(rob_count), 0);
    chk("R10 drained sched", int'(sched_count), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule